// File: doc/BRIEF.md
# Dual LED Blink Controller

This block drives two LED outputs, each steered by its own 8-bit control register. A 2-bit mode field in each register picks one of four behaviours: dark, lit, a symmetric blink with a 1 s period, and a sparse blink with a 2 s period that is lit for a quarter of it. Software reaches the two registers over a plain synchronous register bus. A write lands on the next clock edge. A read returns data combinationally for the address presented.

One prescaler divides the system clock into a single-cycle tick every half second. The parameter `CLKS_PER_HALF_SEC` sets its length. Each tick advances a free-running 2-bit phase counter. Both LEDs read this same phase, so LEDs set to the same blink mode stay in step. A mode change never restarts the phase.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00, both LEDs are dark, and the phase counter is 0.
- R2: Mode code 00 in bits [1:0] keeps the LED dark in every phase.
- R3: Mode code 11 in bits [1:0] keeps the LED lit in every phase.
- R4: Mode code 01 lights the LED while phase bit 0 is 0. The result is `CLKS_PER_HALF_SEC` cycles lit followed by the same number dark, repeating.
- R5: Mode code 10 lights the LED only while the phase equals 0. The result is `CLKS_PER_HALF_SEC` cycles lit followed by three times that many dark, repeating.
- R6: Bits [7:2] of a control register are ignored on write and always read back as 0.
- R7: Address 0 selects the register of LED 0 and address 1 selects the register of LED 1; the two are independent. Other addresses read 0, and writes to them change nothing.
- R8: The phase advances by one, modulo 4, every `CLKS_PER_HALF_SEC` clock cycles counted from reset release, and register writes never disturb it.
- R9: A write changes the addressed register, and therefore its LED, at the clock edge that samples the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| ledOut | output | 2 | LED drive, one bit per LED, 1 = lit |

## Verification
The bench checks the LEDs on every cycle across several full 2 s periods. A prescaler that is off by one cycle would slip against the bench's cycle-count model within a few ticks, and swapped phase decodes would put the 25% pattern in the wrong slot. Writes land at varied points inside a phase, so a design that cleared the phase on a write would lose step with the free-running model. The bench writes 0xFF and reads back 0x03, and writes to an unmapped address, which catches reserved bits that get stored and address decoding that aliases. A reset in the middle of a run must return both registers and the phase to zero, even while the LEDs are blinking.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  localparam int LED_COUNT = 2;
  localparam int REG_W     = 8;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_DARK = 2'b00,
    MODE_FAST = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_LIT  = 2'b11
  } led_mode_e;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic [LED_COUNT-1:0] wrLed;
    logic [LED_COUNT-1:0] rdLed;
  } led_strobe_t;

endpackage

// File: rtl/led_blink_timebase.sv
module led_blink_timebase #(
  parameter int CLKS_PER_HALF_SEC = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] phase
);

  localparam int DIV    = (CLKS_PER_HALF_SEC > 1) ? CLKS_PER_HALF_SEC : 2;
  localparam int CNT_W  = $clog2(DIV);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic             tick;

  assign tick = (divCnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      phase  <= '0;
    end else if (tick) begin
      divCnt <= '0;
      phase  <= phase + 2'd1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  a_r8_phase_hold : assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  a_r8_phase_step : assert property (@(posedge clk) disable iff (rst)
    tick |=> (phase == $past(phase) + 2'd1));

  a_r8_counter_range : assert property (@(posedge clk) disable iff (rst)
    divCnt <= CNT_MAX);

endmodule

// File: rtl/led_blink_decode.sv
module led_blink_decode
  import led_blink_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output led_strobe_t       strobe
);

  for (genvar i = 0; i < LED_COUNT; i++) begin : g_sel
    logic hit;
    assign hit               = (regAddr == ADDR_W'(i));
    assign strobe.rdLed[i]   = hit;
    assign strobe.wrLed[i]   = hit & regWrEn;
  end

  always_comb begin
    a_r7_sel_onehot : assert ($onehot0(strobe.rdLed));
  end

endmodule

// File: rtl/led_blink_datapath.sv
module led_blink_datapath
  import led_blink_pkg::*;
#(
  parameter int CLKS_PER_HALF_SEC = 25_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  led_strobe_t          strobe,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic [LED_COUNT-1:0] ledOut
);

  logic [1:0]            phase;
  led_mode_e             modeReg [LED_COUNT];
  logic [REG_W-1:0]      rdTerm  [LED_COUNT];

  led_blink_timebase #(
    .CLKS_PER_HALF_SEC(CLKS_PER_HALF_SEC)
  ) u_timebase (
    .clk  (clk),
    .rst  (rst),
    .phase(phase)
  );

  for (genvar i = 0; i < LED_COUNT; i++) begin : g_led
    always_ff @(posedge clk) begin
      if (rst)                  modeReg[i] <= MODE_DARK;
      else if (strobe.wrLed[i]) modeReg[i] <= led_mode_e'(regWrData[MODE_W-1:0]);
    end

    always_comb begin
      unique case (modeReg[i])
        MODE_DARK: ledOut[i] = 1'b0;
        MODE_FAST: ledOut[i] = ~phase[0];
        MODE_SLOW: ledOut[i] = (phase == 2'd0);
        MODE_LIT:  ledOut[i] = 1'b1;
        default:   ledOut[i] = 1'b0;
      endcase
    end

    assign rdTerm[i] = strobe.rdLed[i] ? {{(REG_W-MODE_W){1'b0}}, modeReg[i]}
                                       : '0;

    a_r2_dark : assert property (@(posedge clk) disable iff (rst)
      (modeReg[i] == MODE_DARK) |-> !ledOut[i]);
    a_r3_lit : assert property (@(posedge clk) disable iff (rst)
      (modeReg[i] == MODE_LIT) |-> ledOut[i]);
    a_r9_write_lands : assert property (@(posedge clk) disable iff (rst)
      strobe.wrLed[i] |=> (modeReg[i] == $past(regWrData[MODE_W-1:0])));
    a_r7_hold : assert property (@(posedge clk) disable iff (rst)
      !strobe.wrLed[i] |=> $stable(modeReg[i]));
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < LED_COUNT; i++) regRdData |= rdTerm[i];
  end

  always_comb begin
    a_r6_reserved_zero : assert (regRdData[REG_W-1:MODE_W] == '0);
  end

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int CLKS_PER_HALF_SEC = 25_000_000,
  parameter int ADDR_W            = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic [LED_COUNT-1:0] ledOut
);

  led_strobe_t strobe;

  led_blink_decode #(
    .ADDR_W(ADDR_W)
  ) u_decode (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  led_blink_datapath #(
    .CLKS_PER_HALF_SEC(CLKS_PER_HALF_SEC)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .ledOut   (ledOut)
  );

endmodule

// File: tb/led_blink_ctrl_tb.sv
module led_blink_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int ADDR_W     = 4;
  localparam int NVEC       = 10;

  // vector: {addr[3:0], data[7:0], holdCycles[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd0, 8'h01, 8'd40},
    {4'd1, 8'h02, 8'd37},
    {4'd0, 8'h02, 8'd33},
    {4'd1, 8'hFE, 8'd35},
    {4'd0, 8'h03, 8'd20},
    {4'd1, 8'h01, 8'd34},
    {4'd5, 8'h03, 8'd18},
    {4'd0, 8'hFD, 8'd29},
    {4'd1, 8'h00, 8'd21},
    {4'd0, 8'h00, 8'd17}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [ADDR_W-1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] ledOut;

  int   nChecks = 0;
  int   nFails  = 0;
  int   edges   = 0;
  logic [1:0] modelMode [2];

  led_blink_ctrl #(
    .CLKS_PER_HALF_SEC(HALF),
    .ADDR_W(ADDR_W)
  ) u_dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .ledOut(ledOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  function automatic logic expLed(input logic [1:0] m, input int e);
    int ph;
    ph = (e / HALF) % 4;
    case (m)
      2'b00:   return 1'b0;
      2'b01:   return (ph % 2) == 0;
      2'b10:   return ph == 0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic checkLeds(input string req);
    for (int i = 0; i < 2; i++)
      check(req, {7'd0, ledOut[i]}, {7'd0, expLed(modelMode[i], edges)});
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
    if (a < 2) modelMode[a[0]] = d[1:0];
  endtask

  task automatic readCheck(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  initial begin
    modelMode[0] = 2'b00;
    modelMode[1] = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    readCheck("R1", 4'd0, 8'h00);
    readCheck("R1", 4'd1, 8'h00);
    checkLeds("R1");

    // vector walk: R2 R3 R4 R5 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      writeReg(VEC[v][19:16], VEC[v][15:8]);
      checkLeds("R9");
      for (int c = 0; c < int'(VEC[v][7:0]); c++) begin
        @(negedge clk);
        checkLeds(modelMode[0] == 2'b10 || modelMode[1] == 2'b10 ? "R5" :
                  (modelMode[0] == 2'b01 || modelMode[1] == 2'b01 ? "R4" : "R2_R3"));
      end
    end

    // R6: reserved bits dropped
    writeReg(4'd0, 8'hFF);
    readCheck("R6", 4'd0, 8'h03);
    writeReg(4'd1, 8'hA6);
    readCheck("R6", 4'd1, 8'h02);

    // R7: unmapped address reads 0, write has no effect
    writeReg(4'd9, 8'h01);
    readCheck("R7", 4'd9, 8'h00);
    readCheck("R7", 4'd0, 8'h03);
    readCheck("R7", 4'd1, 8'h02);
    checkLeds("R7");

    // R8: both LEDs fast blink, must stay in sync across a full period
    writeReg(4'd0, 8'h01);
    writeReg(4'd1, 8'h01);
    for (int c = 0; c < 4*HALF; c++) begin
      @(negedge clk);
      check("R8", {7'd0, ledOut[0]}, {7'd0, ledOut[1]});
      checkLeds("R8");
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelMode[0] = 2'b00;
    modelMode[1] = 2'b00;
    readCheck("R1", 4'd0, 8'h00);
    readCheck("R1", 4'd1, 8'h00);
    checkLeds("R1");
    writeReg(4'd1, 8'h02);
    for (int c = 0; c < 4*HALF; c++) begin
      @(negedge clk);
      checkLeds("R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule